// File: doc/BRIEF.md
# Per-Channel Alarm Interrupt Register Bank

This block gathers the alarm conditions of a four-channel line interface and exposes them through a small read bus. Each channel provides two registers. One shows the present state of seven alarms. The other records which alarms have changed, and which PRBS events have occurred, since software last read it. The bank ORs every pending interrupt bit from every channel onto a single interrupt pin.

The level alarms arrive asynchronously. Each passes through a two-flop synchronizer before the bank uses it. The driver monitor alarm is generated inside the block. A per-channel state machine counts cycles since the last edge of the channel's transmit line signal and declares the line silent after a nominal 128 cycles with no edge.

The silence monitor has two named states:
- `TX_ACTIVE`: the line is toggling. The machine moves to `TX_SILENT` when the counter reaches the threshold with no edge seen.
- `TX_SILENT`: the alarm is raised and the counter is held at the threshold. The machine returns to `TX_ACTIVE` on any edge of the line.

Top module: `alarm_irq_bank`

## Requirements
- R1: Address bits [ADDR_W-1:3] select the channel and bits [2:0] select the register within it. Offset 2 is the interrupt status register and offset 3 is the alarm status register, so channel 0 uses 0x02/0x03, channel 1 uses 0x0A/0x0B, and so on. Any other offset, or a channel that does not exist, reads as zero. Read data appears on `rd_data` in the cycle after `rd_stb` and holds while no read is made.
- R2: The alarm status register bits, from bit 0 upward, are: transmit silence, receive LOS, loss of lock, FIFO near limit, analog LOS, digital LOS, PRBS out of sync. Bit 7 reads 0. Bits 1 to 6 follow their input levels after a two-flop synchronizer.
- R3: Interrupt bits 0 to 3 (transmit silence, receive LOS, loss of lock, FIFO near limit) each set when the matching synchronized level changes, whether it rises or falls. Analog LOS, digital LOS and PRBS out-of-sync set no interrupt bit.
- R4: Interrupt bit 4 sets on a `prbs_err_evt` pulse and bit 5 sets on a `prbs_sat_evt` pulse. Bits 7:6 read 0.
- R5: A read of a channel's interrupt status register returns its current value and clears it to zero.
- R6: An event in the same cycle as the clearing read leaves its bit set after the read.
- R7: `irq` is high exactly when any interrupt status bit of any channel is set.
- R8: The transmit silence alarm rises after TIMEOUT (128) cycles with no edge on the channel's synchronized `tx_line`. Any edge drops it and restarts the count. The counter saturates at TIMEOUT and does not wrap.
- R9: After reset every register bit and `irq` are 0.
- R10: Alarms and events of one channel leave the registers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_line | input | NUM_CH | Monitored transmit line signal, one per channel |
| rx_los_in | input | NUM_CH | Receive loss-of-signal level |
| lock_lost_in | input | NUM_CH | Loss-of-lock level |
| fifo_near_in | input | NUM_CH | Jitter FIFO near-limit level |
| ana_los_in | input | NUM_CH | Analog loss-of-signal level |
| dig_los_in | input | NUM_CH | Digital loss-of-signal level |
| prbs_unsync_in | input | NUM_CH | PRBS detector out-of-sync level |
| prbs_err_evt | input | NUM_CH | One-cycle PRBS error pulse |
| prbs_sat_evt | input | NUM_CH | One-cycle PRBS counter saturation pulse |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table steps through each channel with level patterns that raise single alarms, raise several at once, drop them, and mix latching with non-latching alarms. The expected interrupt values show whether both edge directions are caught and whether analog LOS, digital LOS and out-of-sync are correctly kept out of the latch. Directed tests stop one channel's transmit toggling and check that the silence alarm is absent before about 100 cycles and present after about 160. They also fire a PRBS pulse in the same cycle as the clearing read, read unused offsets while bits are pending, and confirm that one channel's events never show up in another channel's registers.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int REG_W    = 8;
    localparam int OFS_W    = 3;
    localparam int OFS_IRQ  = 2;
    localparam int OFS_STAT = 3;
    localparam int NUM_LVL  = 6;   // externally supplied level alarms
    localparam int NUM_LATCH_LVL = 4; // levels that feed the interrupt latch
    localparam int NUM_IRQ  = 6;

    typedef enum logic [0:0] {
        TX_ACTIVE = 1'b0,
        TX_SILENT = 1'b1
    } tx_mon_e;

    typedef struct packed {
        logic prbs_unsync;
        logic dig_los;
        logic ana_los;
        logic fifo_near;
        logic lock_lost;
        logic rx_los;
    } lvl_t;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/tx_silence_mon.sv
module tx_silence_mon
    import alarm_irq_pkg::*;
#(
    parameter int TIMEOUT = 128,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic silent
);
    tx_mon_e    state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic       prev_q;
    logic       edge_seen;

    assign edge_seen = line_s ^ prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_ACTIVE;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            prev_q  <= line_s;
        end
    end

    // next state and counter
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            TX_ACTIVE: begin
                if (edge_seen) begin
                    cnt_n = '0;
                end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
                    cnt_n   = CNT_W'(TIMEOUT);
                    state_n = TX_SILENT;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            TX_SILENT: begin
                if (edge_seen) begin
                    cnt_n   = '0;
                    state_n = TX_ACTIVE;
                end
            end
            default: begin
                state_n = TX_ACTIVE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        silent = (state_q == TX_SILENT);
    end

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TIMEOUT));
    a_r8_edge_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (state_q == TX_ACTIVE && cnt_q == '0));
    a_r8_silent_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SILENT) |-> (cnt_q == CNT_W'(TIMEOUT)));
endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
    import alarm_irq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LATCH_LVL-1:0] lvl,
    input  logic                     err_evt,
    input  logic                     sat_evt,
    input  logic                     clr,
    output logic [NUM_IRQ-1:0]       irq_q
);
    logic [NUM_LATCH_LVL-1:0] prev_q;
    logic [NUM_IRQ-1:0]       set_vec;
    logic [NUM_IRQ-1:0]       irq_n;

    always_comb begin
        set_vec = {sat_evt, err_evt, lvl ^ prev_q};
        irq_n   = (irq_q & ~{NUM_IRQ{clr}}) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irq_q  <= '0;
        end else begin
            prev_q <= lvl;
            irq_q  <= irq_n;
        end
    end

    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> (irq_q == '0));
    a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((irq_q & $past(set_vec)) == $past(set_vec)));
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && set_vec == '0) |=> $stable(irq_q));
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank
    import alarm_irq_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int TIMEOUT = 128,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tx_line,
    input  logic [NUM_CH-1:0] rx_los_in,
    input  logic [NUM_CH-1:0] lock_lost_in,
    input  logic [NUM_CH-1:0] fifo_near_in,
    input  logic [NUM_CH-1:0] ana_los_in,
    input  logic [NUM_CH-1:0] dig_los_in,
    input  logic [NUM_CH-1:0] prbs_unsync_in,
    input  logic [NUM_CH-1:0] prbs_err_evt,
    input  logic [NUM_CH-1:0] prbs_sat_evt,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);
    logic [CH_W-1:0]    rd_ch;
    logic [OFS_W-1:0]   rd_ofs;
    logic [REG_W-1:0]   stat_reg [NUM_CH];
    logic [REG_W-1:0]   irq_reg  [NUM_CH];
    logic [NUM_CH-1:0]  clr_vec;
    logic [NUM_CH-1:0]  ch_pending;
    logic [REG_W-1:0]   rd_mux;

    assign rd_ch  = rd_addr[ADDR_W-1:OFS_W];
    assign rd_ofs = rd_addr[OFS_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lvl_t               lvl_raw;
        lvl_t               lvl_s;
        logic               line_s;
        logic               silent;
        logic [NUM_IRQ-1:0] irq_bits;

        assign lvl_raw = '{prbs_unsync: prbs_unsync_in[c], dig_los: dig_los_in[c],
                           ana_los: ana_los_in[c], fifo_near: fifo_near_in[c],
                           lock_lost: lock_lost_in[c], rx_los: rx_los_in[c]};

        alarm_sync #(.W(NUM_LVL + 1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     ({lvl_raw, tx_line[c]}),
            .q     ({lvl_s, line_s})
        );

        tx_silence_mon #(.TIMEOUT(TIMEOUT)) u_txmon (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_s (line_s),
            .silent (silent)
        );

        assign clr_vec[c] = rd_stb && (rd_ch == CH_W'(c)) && (rd_ofs == OFS_W'(OFS_IRQ));

        chan_irq_regs u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     ({lvl_s.fifo_near, lvl_s.lock_lost, lvl_s.rx_los, silent}),
            .err_evt (prbs_err_evt[c]),
            .sat_evt (prbs_sat_evt[c]),
            .clr     (clr_vec[c]),
            .irq_q   (irq_bits)
        );

        assign stat_reg[c]   = {1'b0, lvl_s, silent};
        assign irq_reg[c]    = {{(REG_W - NUM_IRQ){1'b0}}, irq_bits};
        assign ch_pending[c] = |irq_bits;
    end

    assign irq = |ch_pending;

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                if (rd_ofs == OFS_W'(OFS_IRQ))       rd_mux = irq_reg[c];
                else if (rd_ofs == OFS_W'(OFS_STAT)) rd_mux = stat_reg[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= rd_mux;
    end

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    a_r2_reserved_msb: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1] == 1'b0);
    a_r1_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: tb/tb_alarm_irq_bank.sv
module tb_alarm_irq_bank;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] tx_line = '0;
    logic [NUM_CH-1:0] rx_los_in = '0, lock_lost_in = '0, fifo_near_in = '0;
    logic [NUM_CH-1:0] ana_los_in = '0, dig_los_in = '0, prbs_unsync_in = '0;
    logic [NUM_CH-1:0] prbs_err_evt = '0, prbs_sat_evt = '0;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              irq;
    logic [NUM_CH-1:0] tx_run = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    alarm_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .tx_line(tx_line),
        .rx_los_in(rx_los_in), .lock_lost_in(lock_lost_in), .fifo_near_in(fifo_near_in),
        .ana_los_in(ana_los_in), .dig_los_in(dig_los_in), .prbs_unsync_in(prbs_unsync_in),
        .prbs_err_evt(prbs_err_evt), .prbs_sat_evt(prbs_sat_evt),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;  // 50 MHz

    // keep enabled transmit lines toggling every 4 cycles
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            tx_line = tx_line ^ tx_run;
        end
    end

    // table: [23:22] channel, [21:16] levels {unsync,dig,ana,fifo,lock,rxlos}, [15:8] status, [7:0] irq
    localparam logic [23:0] VEC [8] = '{
        {2'd0, 6'b000001, 8'h02, 8'h02},
        {2'd0, 6'b000000, 8'h00, 8'h02},
        {2'd1, 6'b111110, 8'h7C, 8'h0C},
        {2'd2, 6'b001000, 8'h10, 8'h00},
        {2'd3, 6'b000111, 8'h0E, 8'h0E},
        {2'd1, 6'b111001, 8'h72, 8'h0E},
        {2'd3, 6'b100111, 8'h4E, 8'h00},
        {2'd2, 6'b010100, 8'h28, 8'h08}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb  = 1'b0;
        d = rd_data;
    endtask

    task automatic set_lv(input int ch, input logic [5:0] lv);
        @(negedge clk);
        rx_los_in[ch]      = lv[0];
        lock_lost_in[ch]   = lv[1];
        fifo_near_in[ch]   = lv[2];
        ana_los_in[ch]     = lv[3];
        dig_los_in[ch]     = lv[4];
        prbs_unsync_in[ch] = lv[5];
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] ad(input int ch, input int ofs);
        return ADDR_W'(ch * 8 + ofs);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        tx_run = '1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 irq pin in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ad(c, 2), d); check("R9 irq reg after reset", d, 8'h00);
            rd(ad(c, 3), d); check("R9 status reg after reset", d, 8'h00);
        end

        // table walk: R2, R3, R5
        foreach (VEC[i]) begin
            set_lv(int'(VEC[i][23:22]), VEC[i][21:16]);
            rd(ad(int'(VEC[i][23:22]), 3), d);
            check("R2 status levels", d, VEC[i][15:8]);
            rd(ad(int'(VEC[i][23:22]), 2), d);
            check("R3 change latch", d, VEC[i][7:0]);
            rd(ad(int'(VEC[i][23:22]), 2), d);
            check("R5 cleared by read", d, 8'h00);
        end
        check("R7 irq low when all clear", {7'b0, irq}, 8'h00);

        // R4 / R10: saturation pulse on channel 3 only
        @(negedge clk); prbs_sat_evt[3] = 1'b1;
        @(negedge clk); prbs_sat_evt[3] = 1'b0;
        check("R7 irq high with pending bit", {7'b0, irq}, 8'h01);
        // R1: unused offsets and nonzero offsets read zero
        rd(ad(3, 0), d); check("R1 unused offset 0", d, 8'h00);
        rd(ad(3, 5), d); check("R1 unused offset 5", d, 8'h00);
        rd(ad(2, 2), d); check("R10 other channel untouched", d, 8'h00);
        rd(ad(3, 2), d); check("R4 saturation bit5", d, 8'h20);
        rd(ad(3, 2), d); check("R5 cleared after read", d, 8'h00);

        // R6: error pulse in same cycle as clearing read
        @(negedge clk); prbs_err_evt[0] = 1'b1;
        @(negedge clk); prbs_err_evt[0] = 1'b0;
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = ad(0, 2); prbs_err_evt[0] = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; prbs_err_evt[0] = 1'b0;
        check("R4 error bit4 returned", rd_data, 8'h10);
        rd(ad(0, 2), d); check("R6 event at clear kept", d, 8'h10);
        rd(ad(0, 2), d); check("R5 clear after kept event", d, 8'h00);

        // R8: stop toggling channel 2
        @(negedge clk); tx_run[2] = 1'b0;
        repeat (95) @(negedge clk);
        rd(ad(2, 3), d); check("R8 no alarm before timeout", d & 8'h01, 8'h00);
        repeat (60) @(negedge clk);
        rd(ad(2, 3), d); check("R8 alarm after timeout", d & 8'h01, 8'h01);
        check("R7 irq from silence alarm", {7'b0, irq}, 8'h01);
        rd(ad(2, 2), d); check("R3 rise of silence alarm", d, 8'h01);
        rd(ad(1, 2), d); check("R10 channel 1 unaffected", d, 8'h00);
        repeat (300) @(negedge clk);
        rd(ad(2, 3), d); check("R8 alarm stays while silent", d & 8'h01, 8'h01);
        rd(ad(2, 2), d); check("R8 no re-trigger while saturated", d, 8'h00);
        @(negedge clk); tx_run[2] = 1'b1;
        repeat (12) @(negedge clk);
        rd(ad(2, 3), d); check("R8 edge drops alarm", d & 8'h01, 8'h00);
        rd(ad(2, 2), d); check("R3 fall of silence alarm", d, 8'h01);
        check("R7 irq low at end", {7'b0, irq}, 8'h00);

        finish_run();
    end
endmodule